// File: doc/BRIEF.md
# Flash Region Access Protection Checker

This block decides, for every flash access request from the host, whether the request must be refused. It holds a small set of protection regions. Each region has a 4 KB-aligned base, an inclusive upper bound and separate read and write protect enables. Each region also carries two 16-bit override masks, one for reads and one for writes, which exempt chosen request tags from that region's protection. A single global offset register is added to every request address before any comparison.

A request presents an address, a byte length, a 4-bit tag and a write flag, which covers both writes and erases. All regions are tested at the same time. One clock after the request strobe, the block raises a one-cycle result strobe with a blocked flag. The regions and the offset are loaded through a plain register-write port that has a selector and a region index.

Top module: `flash_guard`

## Requirements
- R1: After reset, `rsp_valid` is low, the offset is zero, and every region has both protect bits and both override masks clear, so no request is blocked.
- R2: The effective address is `req_addr` plus the offset register (selector 3, all 32 bits of `cfg_wdata`, `cfg_idx` ignored). All region comparisons use the effective address.
- R3: A region's upper bound is its high register (selector 2'd1) with bits 31:12 kept and bits 11:0 forced to ones. The upper bound is inclusive.
- R4: A request hits a region when the region base is at or below effective address + length − 1 and the effective address is at or below the upper bound. The region base is bits 31:12 of the base register (selector 2'd0) with zero low bits. A partial overlap counts as a hit.
- R5: A read (`req_write`=0) is blocked when a hit region has its read-protect bit set (bit 0 of the base register) and bit `req_tag` of that region's read override mask (override register bits 31:16, selector 2'd2) is clear.
- R6: A write or erase (`req_write`=1) is blocked when a hit region has its write-protect bit set (bit 1 of the base register) and bit `req_tag` of the write override mask (override register bits 15:0) is clear.
- R7: The blocked result is the OR over all regions. A region whose override exempts the tag does not stop another hit region from blocking.
- R8: A request with zero length is never blocked.
- R9: A region register write whose `cfg_idx` is at or above `NUM_REGIONS` changes no region.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. `rsp_blocked` is low whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base/flags, 1 high, 2 overrides, 3 global offset |
| cfg_idx | input | IDX_W | Region index for selectors 0 to 2 |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request flash address before the offset |
| req_len | input | LEN_W | Request length in bytes |
| req_tag | input | 4 | Request tag, indexes the override masks |
| req_write | input | 1 | 1 for write or erase, 0 for read |
| rsp_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| rsp_blocked | output | 1 | Request refused |

## Verification
The overlap test is probed on both sides of each bound. A request that ends one byte below a base is told apart from one that crosses it. An address exactly at the forced-ones upper bound is told apart from one a byte above it, and a zero-length request lands inside a protected range. The permission logic is exercised with the same address under different tags and directions, which separates the read mask from the write mask and the read enable from the write enable. It also shows an exempt region being overruled by an overlapping region that is not exempt. Requests placed with and without the offset confirm it is applied. Writes to indices beyond the region count, including ones that would alias onto region 0, are shown to leave the regions intact.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam int TAG_W      = 4;
  localparam int MASK_W     = 1 << TAG_W;
  localparam int PAGE_BITS  = 12;
  localparam int RD_FLAG    = 0;
  localparam int WR_FLAG    = 1;

  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_HIGH   = 2'd1,
    SEL_OVR    = 2'd2,
    SEL_OFFSET = 2'd3
  } cfg_sel_e;

  // Address after the global offset is applied (wraparound not handled).
  function automatic logic [31:0] shifted_addr(input logic [31:0] a, input logic [31:0] off);
    return a + off;
  endfunction

  // Lowest byte covered by a region.
  function automatic logic [31:0] floor_of(input logic [31:0] reg_val);
    return {reg_val[31:PAGE_BITS], {PAGE_BITS{1'b0}}};
  endfunction

  // Highest byte covered by a region, inclusive, page granular.
  function automatic logic [31:0] ceil_of(input logic [31:0] reg_val);
    return {reg_val[31:PAGE_BITS], {PAGE_BITS{1'b1}}};
  endfunction

  // Inclusive overlap of [ea, ea+len-1] with [lo, hi]; empty requests never overlap.
  function automatic logic spans(input logic [31:0] ea, input logic [31:0] len,
                                 input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] last;
    last = ea + len - 32'd1;
    return (len != 32'd0) && (lo <= last) && (ea <= hi);
  endfunction

endpackage

// File: rtl/guard_region_bank.sv
module guard_region_bank
  import flash_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_W       = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_sel,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [31:0]                 cfg_wdata,
  output logic [NUM_REGIONS-1:0][31:0] base_q,
  output logic [NUM_REGIONS-1:0][31:0] high_q,
  output logic [NUM_REGIONS-1:0][31:0] ovr_q,
  output logic [31:0]                 offset_q
);

  cfg_sel_e sel;
  logic     idx_in_range;
  logic     region_write;
  logic     rejected_write;

  assign sel            = cfg_sel_e'(cfg_sel);
  assign idx_in_range   = (int'(cfg_idx) < NUM_REGIONS);
  assign region_write   = cfg_we && (sel != SEL_OFFSET);
  assign rejected_write = region_write && !idx_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset_q <= '0;
    else if (cfg_we && sel == SEL_OFFSET) offset_q <= cfg_wdata;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic picked;
    assign picked = region_write && idx_in_range && (int'(cfg_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        high_q[g] <= '0;
        ovr_q[g]  <= '0;
      end else if (picked) begin
        unique case (sel)
          SEL_BASE: base_q[g] <= cfg_wdata;
          SEL_HIGH: high_q[g] <= cfg_wdata;
          SEL_OVR:  ovr_q[g]  <= cfg_wdata;
          default:  ;
        endcase
      end
    end
  end

  // R9
  rejected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected_write |=> ($stable(base_q) && $stable(high_q) && $stable(ovr_q)));

endmodule

// File: rtl/guard_region_match.sv
module guard_region_match
  import flash_guard_pkg::*;
(
  input  logic [31:0]      ea,
  input  logic [31:0]      len,
  input  logic [TAG_W-1:0] tag,
  input  logic             is_write,
  input  logic [31:0]      base_reg,
  input  logic [31:0]      high_reg,
  input  logic [31:0]      ovr_reg,
  output logic             hit,
  output logic             block
);

  logic [MASK_W-1:0] rd_mask;
  logic [MASK_W-1:0] wr_mask;
  logic              guarded;
  logic              exempt;

  assign rd_mask = ovr_reg[31:16];
  assign wr_mask = ovr_reg[15:0];

  assign hit     = spans(ea, len, floor_of(base_reg), ceil_of(high_reg));
  assign guarded = is_write ? base_reg[WR_FLAG] : base_reg[RD_FLAG];
  assign exempt  = is_write ? wr_mask[tag] : rd_mask[tag];
  assign block   = hit && guarded && !exempt;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_W       = 3,
  parameter int LEN_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [3:0]       req_tag,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_blocked
);

  logic [NUM_REGIONS-1:0][31:0] base_q;
  logic [NUM_REGIONS-1:0][31:0] high_q;
  logic [NUM_REGIONS-1:0][31:0] ovr_q;
  logic [31:0]                  offset_q;
  logic [31:0]                  ea;
  logic [31:0]                  len32;
  logic [NUM_REGIONS-1:0]       hit_vec;
  logic [NUM_REGIONS-1:0]       block_vec;
  logic                         any_block;

  guard_region_bank #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .base_q   (base_q),
    .high_q   (high_q),
    .ovr_q    (ovr_q),
    .offset_q (offset_q)
  );

  assign ea    = shifted_addr(req_addr, offset_q);
  assign len32 = 32'(req_len);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    guard_region_match u_match (
      .ea      (ea),
      .len     (len32),
      .tag     (req_tag),
      .is_write(req_write),
      .base_reg(base_q[g]),
      .high_reg(high_q[g]),
      .ovr_reg (ovr_q[g]),
      .hit     (hit_vec[g]),
      .block   (block_vec[g])
    );
  end

  assign any_block = |block_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_blocked <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_blocked <= req_valid && any_block;
    end
  end

  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10
  blocked_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> rsp_valid);
  // R8
  empty_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == '0) |=> !rsp_blocked);
  // R4
  block_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_vec & ~hit_vec) == '0);

endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;

  localparam int NR  = 4;
  localparam int IW  = 3;
  localparam int LW  = 12;
  localparam logic [31:0] OFFSET = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [3:0]    req_tag = '0;
  logic          req_write = 1'b0;
  logic          rsp_valid;
  logic          rsp_blocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_guard #(.NUM_REGIONS(NR), .IDX_W(IW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_tag(req_tag), .req_write(req_write), .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked)
  );

  // {write, tag, len, addr, expected blocked, requirement number}
  localparam int VN = 14;
  localparam logic [57:0] VEC [VN] = '{
    {1'b0, 4'd0, 12'd4,  32'h000F_0000, 1'b1, 8'd5},  // R5 read, tag not exempt
    {1'b0, 4'd5, 12'd4,  32'h000F_0000, 1'b0, 8'd5},  // R5 read mask exempts tag 5
    {1'b1, 4'd5, 12'd4,  32'h000F_0000, 1'b1, 8'd6},  // R6 write mask lacks tag 5
    {1'b1, 4'd2, 12'd4,  32'h000F_0000, 1'b0, 8'd6},  // R6 write mask exempts tag 2
    {1'b0, 4'd0, 12'd16, 32'h000E_FFF8, 1'b1, 8'd4},  // R4 crosses base
    {1'b0, 4'd0, 12'd8,  32'h000E_FFF8, 1'b0, 8'd4},  // R4 ends one byte below base
    {1'b0, 4'd0, 12'd1,  32'h000F_3FFF, 1'b1, 8'd3},  // R3 last byte of bound
    {1'b0, 4'd0, 12'd1,  32'h000F_4000, 1'b0, 8'd3},  // R3 one past bound
    {1'b0, 4'd1, 12'd4,  32'h001F_0800, 1'b0, 8'd5},  // R5 write-only region, read passes
    {1'b1, 4'd1, 12'd4,  32'h001F_0800, 1'b1, 8'd6},  // R6 write-only region blocks
    {1'b1, 4'd0, 12'd4,  32'h002F_0000, 1'b0, 8'd4},  // R4 hit but no enables
    {1'b0, 4'd0, 12'd0,  32'h000F_0000, 1'b0, 8'd8},  // R8 zero length
    {1'b0, 4'd0, 12'd4,  32'h0010_0000, 1'b0, 8'd2},  // R2 offset moves it past bound
    {1'b0, 4'd5, 12'd4,  32'h000F_2000, 1'b1, 8'd7}   // R7 region 3 overrules exemption
  };

  task automatic check(input bit got, input bit exp, input int rq, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0b expected %0b", rq, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [IW-1:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request(input bit w, input logic [3:0] t, input logic [LW-1:0] l,
                         input logic [31:0] a, output bit v, output bit b);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_tag = t; req_len = l; req_addr = a;
    @(negedge clk);
    v = rsp_valid; b = rsp_blocked;
    req_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit v, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid, 1'b0, 1, "rsp_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid, 1'b0, 1, "rsp_valid after reset");
    request(1'b0, 4'd0, 12'd4, 32'h0000_0000, v, b);
    check(v, 1'b1, 10, "strobe after request");
    check(b, 1'b0, 1, "read unblocked with reset regions");
    request(1'b1, 4'd0, 12'hFFF, 32'h0000_0000, v, b);
    check(b, 1'b0, 1, "write unblocked with reset regions");
    @(negedge clk);
    // R10 single-cycle strobe
    check(rsp_valid, 1'b0, 10, "strobe drops");
    check(rsp_blocked, 1'b0, 10, "blocked low without strobe");

    cfg_write(2'd3, '0, OFFSET);
    cfg_write(2'd0, 3'd0, 32'h0010_0003);
    cfg_write(2'd1, 3'd0, 32'h0010_3000);
    cfg_write(2'd2, 3'd0, 32'h0020_0004);
    cfg_write(2'd0, 3'd1, 32'h0020_0002);
    cfg_write(2'd1, 3'd1, 32'h0020_0000);
    cfg_write(2'd0, 3'd2, 32'h0030_0000);
    cfg_write(2'd1, 3'd2, 32'h0030_0000);
    cfg_write(2'd0, 3'd3, 32'h0010_2001);
    cfg_write(2'd1, 3'd3, 32'h0010_2000);
    // R9 out-of-range writes, including an index that aliases region 0 modulo 4
    cfg_write(2'd2, 3'd4, 32'hFFFF_FFFF);
    cfg_write(2'd0, 3'd5, 32'h0040_0003);
    cfg_write(2'd1, 3'd5, 32'h0040_0000);

    for (int k = 0; k < VN; k++) begin
      request(VEC[k][57], VEC[k][56:53], VEC[k][52:41], VEC[k][40:9], v, b);
      check(v, 1'b1, 10, $sformatf("vector %0d strobe", k));
      check(b, VEC[k][8], int'(VEC[k][7:0]), $sformatf("vector %0d blocked", k));
    end

    // R9 rejected writes left region 0 unexempted and created no region at 0x0040_0000
    request(1'b0, 4'd0, 12'd4, 32'h000F_0000, v, b);
    check(b, 1'b1, 9, "alias write did not reach region 0");
    request(1'b1, 4'd0, 12'd4, 32'h003F_0000, v, b);
    check(b, 1'b0, 9, "no region from index 5");

    // R2 offset change shifts the match
    cfg_write(2'd3, '0, 32'h0000_0000);
    request(1'b0, 4'd0, 12'd4, 32'h0010_0000, v, b);
    check(b, 1'b1, 2, "zero offset matches raw address");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule